// File: doc/BRIEF.md
# Hardware Error Recovery Sequencer

This block takes over the processor after any checker reports a hardware error. The same fixed, ordered sequence runs for every kind of error, with no firmware involved. First it stops further updates to the checkpointed state. Next it lets committed stores leave the first-level cache. It then resets the critical latches, followed by the cache arrays and the branch target buffer. After that it scrubs the checkpoint register file in two passes: the first pass corrects, and the second pass confirms that no error persists. If the scrub is clean, it forces a serialization restart and watches for the first instruction to complete. A successful recovery ends with a logging interrupt. A failure of any kind ends in a checkstop.

The sequencer talks to its neighbours over simple request/acknowledge pairs and a single-ported view of the checkpoint register file. The file returns corrected data and its ECC status one cycle after each read. During the first pass, every corrected word goes back to the address it came from, and a strobe refreshes the shadow copies of that register at the same time. The register count is a parameter.

Top module: `recov_seq_top`

## Requirements
- R1: On the clock edge that samples `err_i` high while the block is idle, `freeze_o` goes high. It stays high through the store drain, both resets and both scrub passes. It is low in the cycle in which `restart_o` pulses.
- R2: `drain_req_o` is raised first and held until `drain_ack_i` is seen. No reset request appears before that acknowledge.
- R3: `latch_rst_req_o` is held until its acknowledge. Only then is `array_rst_req_o` raised and held until its own acknowledge. The two requests are never high together.
- R4: Pass one reads addresses 0 to REGS-1 in ascending order, one per cycle. One cycle after each read, the returned data is written back to the same address with `rf_we_o` and `shadow_upd_o` both high. Pass one therefore makes REGS writes when it is clean.
- R5: An uncorrectable status (`rf_ue_i`) in pass one raises `chkstop_o` in the next cycle. That word is not written, and no read is issued after the cycle in which the status arrives.
- R6: Pass two starts right after pass one and reads every address again in ascending order without writing. A correctable or uncorrectable status in pass two leads to checkstop.
- R7: After a clean pass two, `restart_o` pulses for one cycle. If `err_i` is high in that cycle, or at any later cycle before `instr_done_i`, the block checkstops.
- R8: When `instr_done_i` arrives after the restart, `log_irq_o` and `done_o` pulse together for one cycle. The block then returns to idle with `freeze_o` low.
- R9: Checkstop is sticky until reset. While in checkstop, `chkstop_o` and `freeze_o` stay high, all requests, reads and restarts stay low, and `err_i` and `instr_done_i` have no effect.
- R10: An `err_i` pulse during the drain, the resets or the scrub passes is ignored: the recovery still completes normally.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Error reported by any checker |
| drain_req_o | output | 1 | Request to forward buffered committed stores |
| drain_ack_i | input | 1 | Store drain finished |
| latch_rst_req_o | output | 1 | Request to reset critical latches |
| latch_rst_ack_i | input | 1 | Latch reset finished |
| array_rst_req_o | output | 1 | Request to reset cache arrays and branch target buffer |
| array_rst_ack_i | input | 1 | Array reset finished |
| freeze_o | output | 1 | Checkpoint state must not be updated |
| rf_rd_en_o | output | 1 | Register file read strobe |
| rf_raddr_o | output | AW | Read address |
| rf_rdata_i | input | DATA_W | Corrected read data, one cycle after the read |
| rf_ce_i | input | 1 | Correctable error on the returned word |
| rf_ue_i | input | 1 | Uncorrectable error on the returned word |
| rf_we_o | output | 1 | Write-back strobe |
| rf_waddr_o | output | AW | Write-back address |
| rf_wdata_o | output | DATA_W | Write-back data |
| shadow_upd_o | output | 1 | Refresh shadow copies of the written register |
| restart_o | output | 1 | One-cycle serialization restart request |
| instr_done_i | input | 1 | First instruction after the restart has completed |
| log_irq_o | output | 1 | One-cycle interrupt requesting diagnostic logging |
| done_o | output | 1 | One-cycle pulse on successful recovery |
| chkstop_o | output | 1 | Sticky checkstop |

## Verification
The assertions check the following on every cycle:
- the freeze is applied on entry (R1);
- no reset request appears before the drain acknowledge, and the array reset never precedes the latch reset (R2, R3);
- each write-back goes to the address read one cycle earlier, and reads ascend within a pass (R4);
- reads stop after a fault (R5);
- pass-two faults and restart-window errors lead to checkstop (R6, R7);
- checkstop is sticky, and at most one handshake request is high at a time (R9).

Some properties need whole scenarios, so only the bench shows them:
- the exact read and write totals of a full pass;
- the data written back;
- that a transient correctable error is cleared while a solid one trips pass two;
- that errors in the middle of the sequence are ignored;
- the pulse timing of `log_irq_o` and `done_o`.

// File: rtl/recov_pkg.sv
package recov_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FREEZE,
    ST_DRAIN,
    ST_LRST,
    ST_ARST,
    ST_SCRUB1,
    ST_SCRUB2,
    ST_RESTART,
    ST_WAITC,
    ST_LOG,
    ST_CHKSTOP
  } rec_state_e;

  // States in which the checkpoint must stay frozen.
  function automatic logic holds_freeze(input rec_state_e s);
    return (s == ST_FREEZE) || (s == ST_DRAIN) || (s == ST_LRST) ||
           (s == ST_ARST) || (s == ST_SCRUB1) || (s == ST_SCRUB2) ||
           (s == ST_CHKSTOP);
  endfunction

  // States in which a new error means recovery has failed.
  function automatic logic in_restart_window(input rec_state_e s);
    return (s == ST_RESTART) || (s == ST_WAITC);
  endfunction

  // Pass one tolerates correctable errors; pass two tolerates none.
  function automatic logic scrub_fault(input logic second, input logic ce,
                                       input logic ue);
    return ue | (second & ce);
  endfunction

endpackage

// File: rtl/recov_scrub.sv
module recov_scrub
  import recov_pkg::*;
#(
  parameter int REGS   = 256,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              second_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ce_i,
  input  logic              ue_i,
  output logic              rd_en_o,
  output logic [AW-1:0]     addr_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              shadow_o,
  output logic              fin_o,
  output logic              fault_o
);

  localparam logic [AW-1:0] LAST = AW'(REGS - 1);

  logic          busy_q;
  logic [AW-1:0] cnt_q;
  logic          pend_q;
  logic [AW-1:0] pend_addr_q;
  logic          fault_w;

  // A status is pending one cycle after each read.
  assign fault_w = pend_q && scrub_fault(second_i, ce_i, ue_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      if (go_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (fault_w) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
      pend_q      <= busy_q && !fault_w;
      pend_addr_q <= cnt_q;
    end
  end

  assign rd_en_o  = busy_q;
  assign addr_o   = cnt_q;
  assign we_o     = pend_q && !second_i && !ue_i;
  assign waddr_o  = pend_addr_q;
  assign wdata_o  = rdata_i;
  assign shadow_o = we_o;
  assign fin_o    = pend_q && (pend_addr_q == LAST) && !fault_w;
  assign fault_o  = fault_w;

  // R4: write-back targets the address read one cycle before
  p_wb_same_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> ($past(rd_en_o) && (waddr_o == $past(addr_o))));

  // R4: reads ascend by one within a pass
  p_rd_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && $past(rd_en_o)) |-> (addr_o == AW'($past(addr_o) + 1'b1)));

  // R5: no read after the cycle in which a fault arrives
  p_stop_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !rd_en_o);

endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
  import recov_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic drain_ack_i,
  input  logic latch_ack_i,
  input  logic array_ack_i,
  input  logic instr_done_i,
  input  logic scrub_fin_i,
  input  logic scrub_fault_i,
  output logic drain_req_o,
  output logic latch_req_o,
  output logic array_req_o,
  output logic scrub_go_o,
  output logic scrub_second_o,
  output logic restart_o,
  output logic log_irq_o,
  output logic done_o,
  output logic freeze_o,
  output logic chkstop_o
);

  rec_state_e st_q, st_d;
  logic       drained_q, latched_q;
  logic       idle_w, window_w;

  assign idle_w   = (st_q == ST_IDLE);
  assign window_w = in_restart_window(st_q);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:     if (err_i) st_d = ST_FREEZE;
      ST_FREEZE:   st_d = ST_DRAIN;
      ST_DRAIN:    if (drain_ack_i) st_d = ST_LRST;
      ST_LRST:     if (latch_ack_i) st_d = ST_ARST;
      ST_ARST:     if (array_ack_i) st_d = ST_SCRUB1;
      ST_SCRUB1: begin
        if (scrub_fault_i)    st_d = ST_CHKSTOP;
        else if (scrub_fin_i) st_d = ST_SCRUB2;
      end
      ST_SCRUB2: begin
        if (scrub_fault_i)    st_d = ST_CHKSTOP;
        else if (scrub_fin_i) st_d = ST_RESTART;
      end
      ST_RESTART:  st_d = err_i ? ST_CHKSTOP : ST_WAITC;
      ST_WAITC: begin
        if (err_i)             st_d = ST_CHKSTOP;
        else if (instr_done_i) st_d = ST_LOG;
      end
      ST_LOG:      st_d = ST_IDLE;
      ST_CHKSTOP:  st_d = ST_CHKSTOP;
      default:     st_d = ST_CHKSTOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      drained_q <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idle_w) begin
        drained_q <= 1'b0;
        latched_q <= 1'b0;
      end else begin
        if (drain_req_o && drain_ack_i) drained_q <= 1'b1;
        if (latch_req_o && latch_ack_i) latched_q <= 1'b1;
      end
    end
  end

  assign drain_req_o    = (st_q == ST_DRAIN);
  assign latch_req_o    = (st_q == ST_LRST);
  assign array_req_o    = (st_q == ST_ARST);
  assign scrub_go_o     = ((st_q == ST_ARST) && array_ack_i) ||
                          ((st_q == ST_SCRUB1) && scrub_fin_i && !scrub_fault_i);
  assign scrub_second_o = (st_q == ST_SCRUB2);
  assign restart_o      = (st_q == ST_RESTART);
  assign log_irq_o      = (st_q == ST_LOG);
  assign done_o         = (st_q == ST_LOG);
  assign freeze_o       = holds_freeze(st_q);
  assign chkstop_o      = (st_q == ST_CHKSTOP);

  // R1: freeze follows an accepted error at once
  p_freeze_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && err_i) |=> freeze_o);

  // R2: latch reset only after the drain was acknowledged
  p_drain_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req_o |-> drained_q);

  // R3: array reset only after the latch reset was acknowledged
  p_latch_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    array_req_o |-> latched_q);

  // R3: at most one handshake request at a time
  p_one_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_req_o, latch_req_o, array_req_o, restart_o, log_irq_o}));

  // R6: a fault in pass two ends in checkstop
  p_pass2_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_second_o && scrub_fault_i) |=> chkstop_o);

  // R7: an error in the restart window ends in checkstop
  p_window_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (window_w && err_i) |=> chkstop_o);

  // R9: checkstop is sticky and silent
  p_chk_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chkstop_o |=> (chkstop_o && !restart_o && !done_o && !scrub_go_o));

endmodule

// File: rtl/recov_seq_top.sv
module recov_seq_top #(
  parameter int REGS   = 256,
  parameter int DATA_W = 64,
  localparam int AW    = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_i,
  output logic              drain_req_o,
  input  logic              drain_ack_i,
  output logic              latch_rst_req_o,
  input  logic              latch_rst_ack_i,
  output logic              array_rst_req_o,
  input  logic              array_rst_ack_i,
  output logic              freeze_o,
  output logic              rf_rd_en_o,
  output logic [AW-1:0]     rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  input  logic              rf_ce_i,
  input  logic              rf_ue_i,
  output logic              rf_we_o,
  output logic [AW-1:0]     rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              shadow_upd_o,
  output logic              restart_o,
  input  logic              instr_done_i,
  output logic              log_irq_o,
  output logic              done_o,
  output logic              chkstop_o
);

  logic scrub_go, scrub_second, scrub_fin, scrub_fault;

  recov_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .err_i          (err_i),
    .drain_ack_i    (drain_ack_i),
    .latch_ack_i    (latch_rst_ack_i),
    .array_ack_i    (array_rst_ack_i),
    .instr_done_i   (instr_done_i),
    .scrub_fin_i    (scrub_fin),
    .scrub_fault_i  (scrub_fault),
    .drain_req_o    (drain_req_o),
    .latch_req_o    (latch_rst_req_o),
    .array_req_o    (array_rst_req_o),
    .scrub_go_o     (scrub_go),
    .scrub_second_o (scrub_second),
    .restart_o      (restart_o),
    .log_irq_o      (log_irq_o),
    .done_o         (done_o),
    .freeze_o       (freeze_o),
    .chkstop_o      (chkstop_o)
  );

  recov_scrub #(.REGS(REGS), .DATA_W(DATA_W)) u_scrub (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (scrub_go),
    .second_i (scrub_second),
    .rdata_i  (rf_rdata_i),
    .ce_i     (rf_ce_i),
    .ue_i     (rf_ue_i),
    .rd_en_o  (rf_rd_en_o),
    .addr_o   (rf_raddr_o),
    .we_o     (rf_we_o),
    .waddr_o  (rf_waddr_o),
    .wdata_o  (rf_wdata_o),
    .shadow_o (shadow_upd_o),
    .fin_o    (scrub_fin),
    .fault_o  (scrub_fault)
  );

  // R1: no register traffic without the freeze
  p_rf_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_en_o || rf_we_o) |-> freeze_o);

endmodule

// File: tb/recov_seq_top_tb_top.sv
`timescale 1ns/1ps
module recov_seq_top_tb_top;
  localparam int REGS = 256;
  localparam int DW   = 64;
  localparam int AW   = $clog2(REGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_i = 1'b0, instr_done_i = 1'b0;
  logic drain_ack_i = 1'b0, latch_rst_ack_i = 1'b0, array_rst_ack_i = 1'b0;
  logic drain_req_o, latch_rst_req_o, array_rst_req_o, freeze_o;
  logic rf_rd_en_o, rf_we_o, shadow_upd_o, restart_o, log_irq_o, done_o, chkstop_o;
  logic [AW-1:0] rf_raddr_o, rf_waddr_o;
  logic [DW-1:0] rf_rdata_i, rf_wdata_o;
  logic rf_ce_i, rf_ue_i;

  always #2.5 clk = ~clk;

  recov_seq_top #(.REGS(REGS), .DATA_W(DW)) dut_i (.*);

  int checks = 0, failures = 0;
  bit ce_mask [REGS];
  bit ue_mask [REGS];
  bit solid   [REGS];
  int wr_gen  [REGS];
  int run_id = 0;

  function automatic logic [DW-1:0] gold(input int a);
    return {32'(a) * 32'h9E3779B1, 32'h5A5A0000 ^ 32'(a)};
  endfunction

  // Register file model: status one cycle after each read.
  bit          rd_v = 1'b0;
  logic [AW-1:0] rd_a = '0;
  always @(posedge clk) begin
    rd_v <= rf_rd_en_o;
    rd_a <= rf_raddr_o;
    if (rf_we_o) wr_gen[rf_waddr_o] <= run_id;
  end
  assign rf_rdata_i = gold(int'(rd_a));
  assign rf_ce_i = rd_v && ce_mask[rd_a] && (solid[rd_a] || wr_gen[rd_a] != run_id);
  assign rf_ue_i = rd_v && ue_mask[rd_a];

  // Handshake responders: acknowledge two cycles after a request.
  int dc = 0, lc = 0, ac = 0;
  always @(negedge clk) begin
    if (!drain_req_o) begin dc = 0; drain_ack_i = 1'b0; end
    else if (dc == 2) drain_ack_i = 1'b1; else dc++;
    if (!latch_rst_req_o) begin lc = 0; latch_rst_ack_i = 1'b0; end
    else if (lc == 2) latch_rst_ack_i = 1'b1; else lc++;
    if (!array_rst_req_o) begin ac = 0; array_rst_ack_i = 1'b0; end
    else if (ac == 2) array_rst_ack_i = 1'b1; else ac++;
  end

  // Monitor, sampled 1 ns after the falling edge.
  int n_reads = 0, n_writes = 0, n_addr_bad = 0, n_wr_bad = 0;
  int n_ord2 = 0, n_ord3 = 0, n_frz_bad = 0, n_restart = 0, n_log = 0;
  bit prev_en = 0, drained = 0, latched = 0;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    #1;
    if (rf_rd_en_o) begin
      n_reads++;
      if (rf_raddr_o != (prev_en ? AW'(prev_addr + 1'b1) : AW'(0))) n_addr_bad++;
    end
    if (rf_we_o) begin
      n_writes++;
      if (!(prev_en && rf_waddr_o == prev_addr && rf_wdata_o == gold(int'(rf_waddr_o)) && shadow_upd_o))
        n_wr_bad++;
    end
    if (latch_rst_req_o && !drained) n_ord2++;
    if (array_rst_req_o && !latched) n_ord3++;
    if (latch_rst_req_o && array_rst_req_o) n_ord3++;
    if ((drain_req_o || latch_rst_req_o || array_rst_req_o || rf_rd_en_o) && !freeze_o) n_frz_bad++;
    if (drain_req_o && drain_ack_i) drained = 1;
    if (latch_rst_req_o && latch_rst_ack_i) latched = 1;
    if (!freeze_o) begin drained = 0; latched = 0; end
    if (restart_o) n_restart++;
    if (log_irq_o) n_log++;
    prev_en = rf_rd_en_o;
    prev_addr = rf_raddr_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    err_i = 0; instr_done_i = 0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic clear_masks();
    run_id++;
    for (int i = 0; i < REGS; i++) begin ce_mask[i] = 0; ue_mask[i] = 0; solid[i] = 0; end
  endtask

  task automatic kick();
    err_i = 1; @(negedge clk); err_i = 0;
  endtask

  task automatic wait_restart(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #2;
      if (restart_o) begin seen = 1; break; end
      if (chkstop_o) break;
    end
  endtask

  task automatic wait_chk(output bit seen);
    seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #2;
      if (chkstop_o) begin seen = 1; break; end
    end
  endtask

  task automatic t_reset_state();
    bit any;
    any = drain_req_o | latch_rst_req_o | array_rst_req_o | freeze_o | rf_rd_en_o |
          rf_we_o | shadow_upd_o | restart_o | log_irq_o | done_o | chkstop_o;
    chk(!any, "R11 outputs low after reset", int'(any), 0);
  endtask

  task automatic t_success(input int ce_a, input int ce_b);
    int r0, w0, ab0, wb0, o20, o30, f0, rs0, l0;
    bit seen;
    clear_masks();
    ce_mask[ce_a] = 1; ce_mask[ce_b] = 1;
    r0 = n_reads; w0 = n_writes; ab0 = n_addr_bad; wb0 = n_wr_bad;
    o20 = n_ord2; o30 = n_ord3; f0 = n_frz_bad; rs0 = n_restart; l0 = n_log;
    kick();
    #2 chk(freeze_o === 1'b1, "R1 freeze after error", int'(freeze_o), 1);
    repeat (100) @(negedge clk);
    kick();   // R10: ignored mid-scrub
    wait_restart(seen);
    chk(seen, "R7 restart pulse after clean scrub", int'(seen), 1);
    chk(freeze_o === 1'b0, "R1 freeze released at restart", int'(freeze_o), 0);
    @(negedge clk); instr_done_i = 1;
    @(negedge clk); instr_done_i = 0;
    #2 chk(log_irq_o && done_o, "R8 log and done pulse", int'({log_irq_o, done_o}), 3);
    @(negedge clk); #2;
    chk(!log_irq_o && !done_o && !freeze_o, "R8 single pulse then idle",
        int'({log_irq_o, done_o, freeze_o}), 0);
    chk(!chkstop_o, "R10 mid-sequence error ignored", int'(chkstop_o), 0);
    chk(n_ord2 == o20, "R2 drain before resets", n_ord2 - o20, 0);
    chk(n_ord3 == o30, "R3 latch reset before array reset", n_ord3 - o30, 0);
    chk(n_frz_bad == f0, "R1 freeze held during sequence", n_frz_bad - f0, 0);
    chk(n_addr_bad == ab0, "R4 ascending read addresses", n_addr_bad - ab0, 0);
    chk(n_writes - w0 == REGS, "R4 one write per register", n_writes - w0, REGS);
    chk(n_wr_bad == wb0, "R4 write-back address, data and shadow", n_wr_bad - wb0, 0);
    chk(n_reads - r0 == 2 * REGS, "R6 two full read passes", n_reads - r0, 2 * REGS);
    chk(n_restart - rs0 == 1 && n_log - l0 == 1, "R7 one restart and one log",
        n_restart - rs0, 1);
  endtask

  task automatic t_ue_pass1();
    int r0, w0, rs0, r1;
    bit seen;
    clear_masks();
    ue_mask[5] = 1;
    r0 = n_reads; w0 = n_writes; rs0 = n_restart;
    kick();
    wait_chk(seen);
    chk(seen, "R5 checkstop on uncorrectable in pass one", int'(seen), 1);
    repeat (3) @(negedge clk);
    #2;
    chk(n_reads - r0 == 7, "R5 reads stop after fault", n_reads - r0, 7);
    chk(n_writes - w0 == 5, "R5 faulty word not written", n_writes - w0, 5);
    r1 = n_reads;
    kick();
    instr_done_i = 1; @(negedge clk); instr_done_i = 0;
    repeat (20) @(negedge clk);
    #2;
    chk(chkstop_o && freeze_o, "R9 checkstop sticky", int'({chkstop_o, freeze_o}), 3);
    chk(!(drain_req_o | latch_rst_req_o | array_rst_req_o | restart_o | done_o) &&
        n_reads == r1 && n_restart == rs0, "R9 silent in checkstop", n_reads - r1, 0);
  endtask

  task automatic t_solid_ce();
    int r0, w0;
    bit seen;
    clear_masks();
    ce_mask[9] = 1; solid[9] = 1;
    r0 = n_reads; w0 = n_writes;
    kick();
    wait_chk(seen);
    chk(seen, "R6 checkstop on persistent correctable", int'(seen), 1);
    repeat (2) @(negedge clk);
    chk(n_reads - r0 == REGS + 11, "R6 pass two stops at fault", n_reads - r0, REGS + 11);
    chk(n_writes - w0 == REGS, "R6 no writes in pass two", n_writes - w0, REGS);
  endtask

  task automatic t_window_err();
    int l0;
    bit seen;
    clear_masks();
    l0 = n_log;
    kick();
    wait_restart(seen);
    chk(seen, "R7 restart reached", int'(seen), 1);
    @(negedge clk); err_i = 1;
    @(negedge clk); err_i = 0;
    #2 chk(chkstop_o === 1'b1, "R7 error before completion checkstops", int'(chkstop_o), 1);
    instr_done_i = 1; @(negedge clk); instr_done_i = 0;
    repeat (3) @(negedge clk);
    chk(n_log == l0, "R7 no log after failed restart", n_log - l0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    #2 t_reset_state();
    t_success(3, 200);
    t_success(0, REGS - 1);
    t_ue_pass1();
    do_reset();
    #2 t_reset_state();
    t_solid_ce();
    do_reset();
    t_window_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule